// File: doc/BRIEF.md
# Exception Vector Remap Unit

This block sits on the processor's address path, in front of the memory decoders. It steers accesses that fall in the low exception-vector window at address zero to one of three backing memories. Every other address passes through unchanged.

A two-bit mode field in a small software-writable register selects the backing memory:

| Mode | Name | Effect on the vector window |
|------|------|-----------------------------|
| `00` | boot | Mapped onto the boot block |
| `01` | flash | Used at its native address |
| `10` | SRAM | Mapped onto static RAM |
| `11` | — | Not allowed |

The translation is purely combinational. It uses the incoming address and the registered mode, so a mode change is seen on the cycle after the write that made it. The unit outputs the translated address, a code for the selected memory, and a flag that says whether the address lay inside the window.

The register port has two locations, chosen by a one-bit select:
- Select 0 holds the mode.
- Select 1 holds a sticky flag. The flag records an attempt to load the forbidden encoding.

Reads are combinational.

Top module: `vector_remap`

## Requirements
- R1: After reset the mode is 00 (boot) and the sticky flag is 0.
- R2: An address with any bit at or above bit 6 set (outside the 64-byte window at zero) leaves the unit unchanged, with target code 01 and window flag 0.
- R3: In mode 00 a window address maps to 0x7FFF_E000 plus its offset (bits 5:0), with target code 00.
- R4: In mode 01 a window address leaves the unit unchanged, with target code 01.
- R5: In mode 10 a window address maps to 0x4000_0000 plus its offset, with target code 10.
- R6: A write to select 0 whose bits 1:0 are 11 is ignored, and the previous mode is kept. Bits 7:2 of any write to select 0 are ignored.
- R7: Such a write sets the sticky flag, which is bit 0 of select 1. The flag stays set until a write to select 1 with bit 0 = 1 clears it. A write to select 1 with bit 0 = 0 leaves the flag unchanged.
- R8: Select 0 reads the mode in bits 1:0 and zero in bits 7:2. Select 1 reads the flag in bit 0 and zero in bits 7:1.
- R9: A mode write is applied at the clock edge where it is presented. The translation on the next cycle already uses the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mode, 1 status |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational |
| bus_addr | input | 32 | Incoming processor address |
| xlat_addr | output | 32 | Translated address |
| xlat_tgt | output | 2 | Selected memory: 00 boot, 01 native, 10 SRAM |
| xlat_hit | output | 1 | Address lies in the vector window |

## Verification
The hardest case to reach is a write of the forbidden encoding while a non-default mode is already active. When the rejected write happens in reset state, "mode kept" cannot be told apart from "mode reset to 00". The stimulus therefore first moves to SRAM mode and then issues the forbidden write. It then sweeps the full window to show the SRAM mapping survived, and reads back the sticky flag. It also clears the flag with a write whose bit 0 is 0, which must not clear it, before the real clear. Every mode is swept over all 64 window offsets and a set of addresses just outside the window and far above it.

// File: rtl/vector_remap.sv
module vector_remap #(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_BYTES = 64,
  parameter logic [31:0] BOOT_BASE = 32'h7FFF_E000,
  parameter logic [31:0] SRAM_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] xlat_addr,
  output logic [1:0]        xlat_tgt,
  output logic              xlat_hit
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam logic [1:0] M_BOOT  = 2'b00;
  localparam logic [1:0] M_FLASH = 2'b01;
  localparam logic [1:0] M_SRAM  = 2'b10;
  localparam logic [1:0] M_RSVD  = 2'b11;

  logic [1:0] mode_q;
  logic       err_q;

  wire wr_mode   = cfg_we && !cfg_sel;
  wire wr_stat   = cfg_we &&  cfg_sel;
  wire mode_bad  = cfg_wdata[1:0] == M_RSVD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_BOOT;
      err_q  <= 1'b0;
    end else begin
      if (wr_mode && !mode_bad) mode_q <= cfg_wdata[1:0];
      if (wr_mode && mode_bad)  err_q  <= 1'b1;
      else if (wr_stat && cfg_wdata[0]) err_q <= 1'b0;
    end
  end

  assign cfg_rdata = cfg_sel ? {7'd0, err_q} : {6'd0, mode_q};

  wire [OFF_W-1:0] offset = bus_addr[OFF_W-1:0];
  assign xlat_hit = bus_addr[ADDR_W-1:OFF_W] == '0;

  always_comb begin
    xlat_addr = bus_addr;
    xlat_tgt  = M_FLASH;
    if (xlat_hit) begin
      unique case (mode_q)
        M_BOOT: begin
          xlat_addr = BOOT_BASE[ADDR_W-1:0] | {{(ADDR_W-OFF_W){1'b0}}, offset};
          xlat_tgt  = M_BOOT;
        end
        M_SRAM: begin
          xlat_addr = SRAM_BASE[ADDR_W-1:0] | {{(ADDR_W-OFF_W){1'b0}}, offset};
          xlat_tgt  = M_SRAM;
        end
        default: begin
          xlat_addr = bus_addr;
          xlat_tgt  = M_FLASH;
        end
      endcase
    end
  end
endmodule

module vector_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [31:0] bus_addr,
  input logic [31:0] xlat_addr,
  input logic [1:0]  xlat_tgt,
  input logic        xlat_hit,
  input logic [1:0]  mode_q,
  input logic        err_q
);
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[31:6] != 0) |-> (xlat_addr == bus_addr && xlat_tgt == 2'b01 && !xlat_hit)); // R2
  AST_BOOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_hit && mode_q == 2'b00) |-> (xlat_addr[31:6] == 26'h1FFFF80 && xlat_addr[5:0] == bus_addr[5:0])); // R3
  AST_FLASH_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> (xlat_addr == bus_addr)); // R4
  AST_SRAM_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_hit && mode_q == 2'b10) |-> (xlat_addr[31:6] == 26'h1000000 && xlat_tgt == 2'b10)); // R5
  AST_RSVD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata[1:0] == 2'b11) |=> $stable(mode_q)); // R6
  AST_RSVD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata[1:0] == 2'b11) |=> err_q); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11); // R6
  AST_RDATA_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:2] == 6'd0); // R8
  AST_MODE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata[1:0] != 2'b11) |=> (mode_q == $past(cfg_wdata[1:0]))); // R9
endmodule

bind vector_remap vector_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
  .xlat_addr(xlat_addr), .xlat_tgt(xlat_tgt), .xlat_hit(xlat_hit),
  .mode_q(mode_q), .err_q(err_q)
);

// File: tb/vector_remap_tb.sv
module vector_remap_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic        cfg_sel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [31:0] bus_addr = 0;
  logic [31:0] xlat_addr;
  logic [1:0]  xlat_tgt;
  logic        xlat_hit;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vector_remap u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .xlat_addr(xlat_addr), .xlat_tgt(xlat_tgt), .xlat_hit(xlat_hit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
  endtask

  task automatic rd(input logic sel, input string req, input logic [7:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 chk(req, {56'd0, cfg_rdata}, {56'd0, exp});
    cfg_sel = 0;
  endtask

  function automatic logic [33:0] model(input logic [1:0] m, input logic [31:0] a);
    logic [31:0] o;
    logic [1:0]  t;
    o = a; t = 2'b01;
    if (a < 32'd64) begin
      if (m == 2'b00) begin o = 32'h7FFF_E000 + a; t = 2'b00; end
      else if (m == 2'b10) begin o = 32'h4000_0000 + a; t = 2'b10; end
    end
    return {t, o};
  endfunction

  task automatic probe(input string req, input logic [1:0] m, input logic [31:0] a);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, {29'd0, xlat_hit, xlat_tgt, xlat_addr}, {29'd0, (a < 32'd64), model(m, a)});
  endtask

  task automatic sweep(input string req, input logic [1:0] m);
    for (int i = 0; i < 64; i++) probe(req, m, i);
  endtask

  task automatic outside(input logic [1:0] m);
    logic [31:0] lst [8];
    lst = '{32'h40, 32'h41, 32'h7F, 32'h100, 32'h4000_0008, 32'h7FFF_E008, 32'h8000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 8; i++) probe("R2", m, lst[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    rd(0, "R1", 8'h00);
    rd(1, "R1", 8'h00);
    sweep("R3", 2'b00);
    outside(2'b00);

    wr(0, 8'h01);
    rd(0, "R8", 8'h01);
    sweep("R4", 2'b01);
    outside(2'b01);

    wr(0, 8'hFE);
    rd(0, "R6", 8'h02);
    sweep("R5", 2'b10);
    outside(2'b10);
    rd(1, "R7", 8'h00);

    wr(0, 8'h03);
    rd(0, "R6", 8'h02);
    sweep("R6", 2'b10);
    rd(1, "R7", 8'h01);
    wr(1, 8'hFE);
    rd(1, "R7", 8'h01);
    wr(0, 8'h00);
    rd(1, "R7", 8'h01);
    wr(1, 8'h01);
    rd(1, "R7", 8'h00);

    // R9: write at an edge, translation changes right after that edge
    @(negedge clk);
    bus_addr = 32'h8;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'h02;
    #1 chk("R9", {32'd0, xlat_addr}, {32'd0, 32'h7FFF_E008});
    @(posedge clk); #1;
    cfg_we = 0;
    chk("R9", {32'd0, xlat_addr}, {32'd0, 32'h4000_0008});
    sweep("R5", 2'b10);
    outside(2'b10);

    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    rd(0, "R1", 8'h00);
    sweep("R3", 2'b00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule